// File: doc/BRIEF.md
# Dual-Mode Limit Counter Timer

This block is a counter/timer on a small word-indexed register bus with one interrupt line. A clock-enable input, `tick_en`, stands for the fixed 500 ns timebase. Each qualified tick adds one unit at bit 9 of the visible count, so the nine low bits of every count value read as zero.

In limit mode the timer counts toward a programmable limit. The tick on which the count would reach the limit returns the count to zero. That same tick sets a sticky reached flag and raises `irq`. Software acknowledges the event by reading the limit register. A second limit index changes the limit without disturbing the running count. When the external `user_mode` input is high, the block becomes a free-running 64-bit counter instead. Software reads that counter as two 32-bit halves and can start and stop it through the status register. In user mode the block never interrupts.

A small state machine holds the operating mode. Its states are `ST_LIMIT` (limit mode, always counting), `ST_URUN` (user mode, counting) and `ST_UHALT` (user mode, stopped). Its transitions are:
- `go_user`: ST_LIMIT to ST_URUN when `user_mode` rises.
- `user_stop`: ST_URUN to ST_UHALT on a status write with bit 0 clear.
- `user_start`: ST_UHALT to ST_URUN on a status write with bit 0 set.
- `go_limit`: either user state to ST_LIMIT when `user_mode` falls.

Top module: `lmt_timer`

## Requirements
- R1: The register index is `bus_addr[4:2]`. Index 0 is the limit, 1 the counter, 2 the limit-without-reset and 3 the status. Indices 4 to 7 read as zero and ignore writes. Index 2 reads as zero.
- R2: Each clock with `tick_en` high while the counter runs adds 0x200 to the count. Bits 8:0 of every count read are zero. Without `tick_en` the count holds.
- R3: In limit mode a counter read returns the count in bits 30:9, zeros in bits 8:0 and the reached flag in bit 31. A counter write in limit mode is ignored.
- R4: In limit mode, a tick whose incremented count is greater than or equal to the limit sets the count to zero, sets the reached flag and raises `irq`. The period is therefore limit/0x200 ticks.
- R5: In limit mode a limit read returns the limit masked with 0x7FFFFFFF. The same read clears the reached flag and lowers `irq`.
- R6: A limit write in limit mode stores `wdata & 0x7FFFFE00`, with a result of zero replaced by 0x7FFFFE00. It also zeroes the count and lowers `irq`, but leaves the reached flag as it was.
- R7: A write to index 2 stores the limit under the same masking and zero rule and leaves the count untouched.
- R8: In user mode, index 0 reads count bits 63:32 and index 1 reads count bits 31:0. A write to index 0 or 1 zeroes the count. The reached flag stays clear and `irq` stays low.
- R9: In user mode, a status write with bit 0 set starts the counter and one with bit 0 clear stops it. A status read returns the running state in bit 0. In limit mode a status read returns 1 and status writes are ignored.
- R10: Any change of `user_mode` zeroes the count, clears the reached flag and lowers `irq`. The limit is kept. Entering user mode leaves the counter running.
- R11: After reset the count is zero, the reached flag and `irq` are clear, the limit is 0x7FFFFE00 and the counter runs in limit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Timebase tick, one count unit per high cycle |
| user_mode | input | 1 | High selects the free-running 64-bit counter mode |
| bus_en | input | 1 | Bus access strobe for one cycle |
| bus_we | input | 1 | High for a write, low for a read |
| bus_addr | input | 3 | Byte address bits 4:2 (register index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during the read cycle |
| irq | output | 1 | Interrupt, high while a limit event is unacknowledged |

## Verification
The embedded assertions check the per-cycle rules on every clock. These are the single-unit count step, the wrap to zero with flag and interrupt on a limit hit, the acknowledge on a limit read, the count clear on a limit write, the untouched count on a limit-without-reset write, the absence of interrupts in user mode and the hold of a stopped counter. Only the bench scenarios show the values seen on the bus. These include the masking and zero substitution of written limits, the placement of the reached flag in counter reads, the split 64-bit words, the ignored indices and writes, and the clean state after a mode switch.

// File: rtl/lmt_pkg.sv
package lmt_pkg;

    localparam int unsigned BUS_W   = 32;
    localparam int unsigned SHIFT   = 9;
    localparam int unsigned CNT_W   = 64;
    localparam int unsigned LIM_W   = BUS_W - 1 - SHIFT;
    localparam int unsigned PER_W   = CNT_W - SHIFT;
    localparam int unsigned IDX_W   = 3;
    localparam int unsigned N_IDX   = 1 << IDX_W;

    typedef enum logic [1:0] {
        ST_LIMIT = 2'd0,
        ST_URUN  = 2'd1,
        ST_UHALT = 2'd2
    } tmr_state_e;

    typedef enum logic [IDX_W-1:0] {
        IX_LIMIT = 3'd0,
        IX_COUNT = 3'd1,
        IX_LIMNR = 3'd2,
        IX_STAT  = 3'd3
    } reg_idx_e;

    typedef struct packed {
        logic wr_lim;
        logic wr_cnt;
        logic wr_limnr;
        logic wr_stat;
        logic rd_lim;
        logic rd_cnt;
        logic rd_stat;
    } strobe_t;

endpackage

// File: rtl/lmt_regdec.sv
module lmt_regdec
    import lmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] idx,
    output strobe_t          stb
);

    logic [N_IDX-1:0] sel;

    for (genvar gi = 0; gi < N_IDX; gi++) begin : g_sel
        assign sel[gi] = bus_en && (idx == gi[IDX_W-1:0]);
    end

    always_comb begin
        stb          = '0;
        stb.wr_lim   = sel[IX_LIMIT] &&  bus_we;
        stb.wr_cnt   = sel[IX_COUNT] &&  bus_we;
        stb.wr_limnr = sel[IX_LIMNR] &&  bus_we;
        stb.wr_stat  = sel[IX_STAT]  &&  bus_we;
        stb.rd_lim   = sel[IX_LIMIT] && !bus_we;
        stb.rd_cnt   = sel[IX_COUNT] && !bus_we;
        stb.rd_stat  = sel[IX_STAT]  && !bus_we;
    end

    // R1: at most one register strobe per access
    p_one_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stb.wr_lim, stb.wr_cnt, stb.wr_limnr, stb.wr_stat,
                  stb.rd_lim, stb.rd_cnt, stb.rd_stat}));

endmodule

// File: rtl/lmt_ctrl.sv
module lmt_ctrl
    import lmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       user_mode,
    input  logic       stat_wr,
    input  logic       stat_bit,
    output tmr_state_e state,
    output logic       is_user,
    output logic       running,
    output logic       mode_chg
);

    tmr_state_e state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            ST_LIMIT: begin
                if (user_mode) state_n = ST_URUN;              // go_user
            end
            ST_URUN: begin
                if (!user_mode)                 state_n = ST_LIMIT;  // go_limit
                else if (stat_wr && !stat_bit)  state_n = ST_UHALT;  // user_stop
            end
            ST_UHALT: begin
                if (!user_mode)                 state_n = ST_LIMIT;  // go_limit
                else if (stat_wr && stat_bit)   state_n = ST_URUN;   // user_start
            end
            default: state_n = ST_LIMIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LIMIT;
        else        state <= state_n;
    end

    always_comb begin
        is_user  = (state != ST_LIMIT);
        running  = (state != ST_UHALT);
        mode_chg = (user_mode != is_user);
    end

    // R9: a stopped user counter stays stopped without a start write
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UHALT && user_mode && !(stat_wr && stat_bit))
        |=> (state == ST_UHALT));

    // R10: the mode follows user_mode one cycle later
    p_mode_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (is_user == $past(user_mode)));

endmodule

// File: rtl/lmt_count.sv
module lmt_count
    import lmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             is_user,
    input  logic             running,
    input  logic             mode_chg,
    input  strobe_t          stb,
    input  logic [LIM_W-1:0] lim_field,
    output logic [PER_W-1:0] cnt,
    output logic [LIM_W-1:0] lim,
    output logic             reached,
    output logic             irq
);

    localparam logic [LIM_W-1:0] LIM_MAX = '1;
    localparam logic [PER_W-1:0] ONE     = {{(PER_W-1){1'b0}}, 1'b1};

    logic [PER_W-1:0] cnt_inc;
    logic [LIM_W-1:0] lim_new;
    logic             hit;
    logic             clr_cnt;
    logic             adv;

    always_comb begin
        cnt_inc = cnt + ONE;
        lim_new = (lim_field == '0) ? LIM_MAX : lim_field;
        hit     = !is_user && (cnt_inc >= {{(PER_W-LIM_W){1'b0}}, lim});
        clr_cnt = (stb.wr_lim) || (stb.wr_cnt && is_user);
        adv     = tick_en && running;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            lim     <= LIM_MAX;
            reached <= 1'b0;
            irq     <= 1'b0;
        end else if (mode_chg) begin
            cnt     <= '0;
            reached <= 1'b0;
            irq     <= 1'b0;
        end else begin
            if (stb.rd_lim && !is_user) begin
                reached <= 1'b0;
                irq     <= 1'b0;
            end
            if (clr_cnt) begin
                cnt <= '0;
                irq <= 1'b0;
                if (!is_user) lim <= lim_new;
            end else if (adv) begin
                if (hit) begin
                    cnt     <= '0;
                    reached <= 1'b1;
                    irq     <= 1'b1;
                end else begin
                    cnt <= cnt_inc;
                end
            end
            if (stb.wr_limnr) lim <= lim_new;
        end
    end

    // R2: an ordinary tick moves the count up by exactly one unit
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !mode_chg && !clr_cnt && !hit) |=> (cnt == $past(cnt) + ONE));

    // R4: a limit hit wraps to zero and flags the event
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && hit && !mode_chg && !clr_cnt) |=> (cnt == '0 && reached && irq));

    // R5: a limit read acknowledges unless a new hit lands at the same edge
    p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.rd_lim && !is_user && !mode_chg && !(adv && hit)) |=> (!irq && !reached));

    // R6: a limit write restarts the count and lowers the interrupt
    p_wrlim_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr_lim && !mode_chg) |=> (cnt == '0 && !irq));

    // R6: the stored limit is never zero
    p_lim_nz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lim != '0);

    // R7: a limit-without-reset write does not touch an idle count
    p_limnr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.wr_limnr && !mode_chg && !tick_en) |=> $stable(cnt));

    // R8: user mode is silent
    p_user_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        is_user |-> (!irq && !reached));

    // R9: a stopped counter holds its value
    p_stop_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !mode_chg && !clr_cnt) |=> $stable(cnt));

endmodule

// File: rtl/lmt_rdmux.sv
module lmt_rdmux
    import lmt_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    input  logic             is_user,
    input  logic             running,
    input  logic [PER_W-1:0] cnt,
    input  logic [LIM_W-1:0] lim,
    input  logic             reached,
    output logic [BUS_W-1:0] rdata
);

    logic [CNT_W-1:0] cnt_full;

    always_comb begin
        cnt_full = {cnt, {SHIFT{1'b0}}};
        unique case (idx)
            IX_LIMIT: rdata = is_user ? cnt_full[CNT_W-1:BUS_W]
                                      : {1'b0, lim, {SHIFT{1'b0}}};
            IX_COUNT: rdata = is_user ? cnt_full[BUS_W-1:0]
                                      : {reached, cnt[LIM_W-1:0], {SHIFT{1'b0}}};
            IX_STAT:  rdata = {{(BUS_W-1){1'b0}}, running};
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/lmt_timer.sv
module lmt_timer
    import lmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        user_mode,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:2]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    strobe_t          stb;
    tmr_state_e       state;
    logic             is_user;
    logic             running;
    logic             mode_chg;
    logic [PER_W-1:0] cnt;
    logic [LIM_W-1:0] lim;
    logic             reached;

    lmt_regdec u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .bus_en (bus_en),
        .bus_we (bus_we),
        .idx    (bus_addr),
        .stb    (stb)
    );

    lmt_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_mode (user_mode),
        .stat_wr   (stb.wr_stat),
        .stat_bit  (bus_wdata[0]),
        .state     (state),
        .is_user   (is_user),
        .running   (running),
        .mode_chg  (mode_chg)
    );

    lmt_count u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .is_user   (is_user),
        .running   (running),
        .mode_chg  (mode_chg),
        .stb       (stb),
        .lim_field (bus_wdata[BUS_W-2:SHIFT]),
        .cnt       (cnt),
        .lim       (lim),
        .reached   (reached),
        .irq       (irq)
    );

    lmt_rdmux u_rd (
        .idx     (bus_addr),
        .is_user (is_user),
        .running (running),
        .cnt     (cnt),
        .lim     (lim),
        .reached (reached),
        .rdata   (bus_rdata)
    );

    // R8: the interrupt line is low whenever the block sits in a user state
    p_user_state_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_LIMIT) |-> !irq);

endmodule

// File: tb/sim_lmt_timer.sv
module sim_lmt_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        user_mode = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    lmt_timer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .user_mode (user_mode),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = idx; bus_wdata = d;
        step();
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] v);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = idx;
        #1 v = bus_rdata;
        step();
        bus_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick_en = 1'b1;
        repeat (n) step();
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R11 irq after reset", {31'b0, irq}, 32'h0);
        rd(3'd1, v); chk("R11 count after reset", v, 32'h0);
        rd(3'd0, v); chk("R11 limit after reset", v, 32'h7FFF_FE00);
        rd(3'd3, v); chk("R11 running after reset", v, 32'h1);
    endtask

    task automatic t_tick();
        logic [31:0] v;
        ticks(3);
        rd(3'd1, v); chk("R2 three ticks", v, 32'h600);
        step(); step();
        rd(3'd1, v); chk("R2 hold without tick", v, 32'h600);
    endtask

    task automatic t_limit_reach();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0BFF);
        rd(3'd1, v); chk("R6 write limit clears count", v, 32'h0);
        rd(3'd0, v); chk("R6 limit masked", v, 32'h0000_0A00);
        ticks(4);
        rd(3'd1, v); chk("R4 before hit", v, 32'h800);
        chk("R4 irq low before hit", {31'b0, irq}, 32'h0);
        ticks(1);
        chk("R4 irq raised on hit", {31'b0, irq}, 32'h1);
        rd(3'd1, v); chk("R3 reached in bit 31, count wrapped", v, 32'h8000_0000);
        rd(3'd0, v); chk("R5 limit read value", v, 32'h0000_0A00);
        chk("R5 irq cleared by limit read", {31'b0, irq}, 32'h0);
        rd(3'd1, v); chk("R5 reached cleared", v, 32'h0);
        ticks(5);
        chk("R4 second period irq", {31'b0, irq}, 32'h1);
        wr(3'd0, 32'h0000_0A00);
        chk("R6 limit write lowers irq", {31'b0, irq}, 32'h0);
        rd(3'd1, v); chk("R6 reached kept on limit write", v, 32'h8000_0000);
        rd(3'd0, v);
        wr(3'd0, 32'h8000_0000);
        rd(3'd0, v); chk("R6 zero limit replaced", v, 32'h7FFF_FE00);
    endtask

    task automatic t_limit_noreset();
        logic [31:0] v;
        wr(3'd0, 32'h0000_1400);
        ticks(3);
        wr(3'd2, 32'h0000_2000);
        rd(3'd1, v); chk("R7 count kept", v, 32'h600);
        rd(3'd0, v); chk("R7 new limit", v, 32'h0000_2000);
        wr(3'd2, 32'h0000_0400);
        ticks(1);
        chk("R7 lowered limit hits", {31'b0, irq}, 32'h1);
        rd(3'd1, v); chk("R4 wrap after lowered limit", v, 32'h8000_0000);
        rd(3'd0, v);
        ticks(1);
        wr(3'd1, 32'h1234_5600);
        rd(3'd1, v); chk("R3 counter write ignored", v, 32'h200);
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R1 unused index reads zero", v, 32'h0);
        rd(3'd0, v); chk("R1 unused write ignored", v, 32'h0000_0400);
        rd(3'd2, v); chk("R1 index 2 reads zero", v, 32'h0);
        wr(3'd3, 32'h0);
        rd(3'd3, v); chk("R9 status write ignored in limit mode", v, 32'h1);
    endtask

    task automatic t_user();
        logic [31:0] v;
        ticks(1);
        chk("R10 irq before switch", {31'b0, irq}, 32'h1);
        user_mode = 1'b1;
        step();
        chk("R10 irq low after switch", {31'b0, irq}, 32'h0);
        rd(3'd1, v); chk("R10 user count zero", v, 32'h0);
        rd(3'd0, v); chk("R8 high word zero", v, 32'h0);
        ticks(4);
        rd(3'd1, v); chk("R8 low word", v, 32'h800);
        rd(3'd3, v); chk("R9 running", v, 32'h1);
        wr(3'd3, 32'h0);
        rd(3'd3, v); chk("R9 stopped", v, 32'h0);
        ticks(3);
        rd(3'd1, v); chk("R9 halted count holds", v, 32'h800);
        wr(3'd3, 32'h1);
        ticks(1);
        rd(3'd1, v); chk("R9 restart counts", v, 32'hA00);
        ticks(20);
        rd(3'd1, v); chk("R8 passes limit freely", v, 32'h3200);
        chk("R8 no irq in user mode", {31'b0, irq}, 32'h0);
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd1, v); chk("R8 index 0 write resets", v, 32'h0);
        ticks(2);
        wr(3'd1, 32'h5);
        rd(3'd1, v); chk("R8 index 1 write resets", v, 32'h0);
    endtask

    task automatic t_back();
        logic [31:0] v;
        ticks(3);
        user_mode = 1'b0;
        step();
        rd(3'd1, v); chk("R10 count cleared on return", v, 32'h0);
        rd(3'd0, v); chk("R10 limit kept", v, 32'h0000_0400);
        rd(3'd3, v); chk("R10 running in limit mode", v, 32'h1);
        ticks(1);
        rd(3'd1, v); chk("R2 counts after return", v, 32'h200);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_tick();
        t_limit_reach();
        t_limit_noreset();
        t_unused();
        t_user();
        t_back();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(5 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule